// File: doc/BRIEF.md
# Keyed-Unlock Clock Source Select Register

This block is a write-protected control register for choosing a clock source. It sits behind a simple byte-wide bus write port. The register has two byte halves at separate addresses. The high half holds the requested source selection and reads back the source currently in use. The low half holds a start bit that launches a source change, a failure flag, and a mirror of the clock source's lock indication. Neither half accepts a data write unless that write lands on the cycle right after a two-byte key sequence written to the same address. Each half has its own keys and its own small unlock state machine. Any other bus activity in between cancels the sequence.

Setting the start bit raises a request toward a modelled clock source and waits for that source to report ready. When ready arrives, the current-source field takes the requested value and the start bit clears by itself. If ready does not come within a programmable number of waiting cycles, the start bit stays set and the failure flag rises. Software can then read the lock mirror to find out why the change failed.

Top module: `clksel_ctrl`

## Requirements
- R1: After synchronous reset, both unlock sequences are idle. The start bit and the failure flag are 0. The current and requested selections both equal the RST_SEL parameter.
- R2: Writing 0x78 and then 0x9A to the high address on consecutive clock cycles opens the high half. A write to the high address on the very next cycle loads wr_data[2:0] into the requested selection.
- R3: Writing 0x46 and then 0x57 to the low address on consecutive clock cycles opens the low half. A write on the very next cycle with wr_data[0]=1 sets the start bit, clears the failure flag and restarts the wait count.
- R4: Any of the following returns the sequence to idle, and the protected write that follows has no effect: a wrong second key, a cycle with no write, a write to another address between the keys, or a gap between the second key and the data write.
- R5: A write to either address without a completed unlock leaves every field unchanged. An unlocked low write with wr_data[0]=0 leaves the start bit unchanged.
- R6: While a request is pending and not failed, osc_ready sampled at a clock edge loads the current selection from the requested selection and clears the start bit.
- R7: If osc_ready is absent for tmo_limit waiting edges in a row (a tmo_limit of 0 acts as 1), the start bit stays 1, the failure flag becomes 1 and sw_req drops. A later osc_ready is then ignored.
- R8: The lock status bit shows osc_lock as sampled at the previous clock edge.
- R9: Reading the high address returns the requested selection in bits [2:0] and the current selection in bits [6:4]. Reading the low address returns the start bit in bit 0, the failure flag in bit 3 and the lock status in bit 5. Every other bit, and every other address, reads 0.
- R10: If a protected high write and osc_ready fall on the same edge, the current selection takes the requested value held before that edge, and the requested selection takes the written value.
- R11: One unlock admits exactly one data write. A second write on the following cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational |
| tmo_limit | input | TMO_W | Number of waiting edges allowed before a request is declared failed |
| osc_ready | input | 1 | Target clock source reports it is ready |
| osc_lock | input | 1 | Lock indication from the clock source |
| cur_sel | output | 3 | Clock source currently selected |
| tgt_sel | output | 3 | Requested clock source |
| sw_req | output | 1 | A source change is pending and has not failed |

## Verification
A protected write to the high half can land on the same edge at which the modelled source reports ready. The change then commits one selection while the register loads another. The bench provokes this on purpose: it opens a request, then runs the high-half key sequence so that its data write coincides with osc_ready. It expects the current selection to take the old requested value and the requested selection to take the newly written one. The random phase then mixes complete, broken and interleaved key sequences with random ready pulses, so that commits and data writes meet many more times. Every cycle is compared with a bench reference model.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int SEL_W = 3;
    localparam int LANES = 2;
    localparam int LN_LO = 0;
    localparam int LN_HI = 1;

    localparam logic [7:0] KEY_LO_A = 8'h46;
    localparam logic [7:0] KEY_LO_B = 8'h57;
    localparam logic [7:0] KEY_HI_A = 8'h78;
    localparam logic [7:0] KEY_HI_B = 8'h9A;

    localparam int LO_EN_BIT   = 0;
    localparam int LO_FAIL_BIT = 3;
    localparam int LO_LOCK_BIT = 5;
    localparam int HI_NEW_LSB  = 0;
    localparam int HI_CUR_LSB  = 4;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lane_st_e;

    typedef struct packed {
        logic             en;
        logic             fail;
        logic             lock;
        logic [SEL_W-1:0] cur;
    } sw_stat_t;

    function automatic logic [7:0] key_first(input int lane);
        return (lane == LN_HI) ? KEY_HI_A : KEY_LO_A;
    endfunction

    function automatic logic [7:0] key_second(input int lane);
        return (lane == LN_HI) ? KEY_HI_B : KEY_LO_B;
    endfunction

    function automatic logic [7:0] pack_hi(input logic [SEL_W-1:0] nsel,
                                           input logic [SEL_W-1:0] cur);
        logic [7:0] b;
        b = '0;
        b[HI_NEW_LSB +: SEL_W] = nsel;
        b[HI_CUR_LSB +: SEL_W] = cur;
        return b;
    endfunction

    function automatic logic [7:0] pack_lo(input sw_stat_t s);
        logic [7:0] b;
        b = '0;
        b[LO_EN_BIT]   = s.en;
        b[LO_FAIL_BIT] = s.fail;
        b[LO_LOCK_BIT] = s.lock;
        return b;
    endfunction

endpackage

// File: rtl/key_lane.sv
module key_lane
    import clksel_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int unsigned LANE_ADDR = 0,
    parameter logic [7:0]  KEY_A     = 8'h00,
    parameter logic [7:0]  KEY_B     = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              grant_o
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(LANE_ADDR);

    lane_st_e st_q, st_d;
    logic     hit;

    assign hit     = wr_en && (wr_addr == MY_ADDR);
    assign grant_o = (st_q == LK_OPEN) && hit;

    always_comb begin
        st_d = LK_IDLE;
        case (st_q)
            LK_IDLE: if (hit && wr_data == KEY_A) st_d = LK_HALF;
            LK_HALF: if (hit && wr_data == KEY_B) st_d = LK_OPEN;
            default: st_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LK_IDLE;
        else     st_q <= st_d;
    end

    // R2 R3
    half_after_key_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_HALF) |-> $past(hit && wr_data == KEY_A));

    // R4
    open_after_keys_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_OPEN) |-> $past(hit && wr_data == KEY_B && st_q == LK_HALF));

    // R11
    open_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_OPEN) |=> (st_q == LK_IDLE));

endmodule

// File: rtl/switch_seq.sv
module switch_seq
    import clksel_pkg::*;
#(
    parameter int TMO_W   = 8,
    parameter int RST_SEL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [SEL_W-1:0] nsel_i,
    input  logic             ready_i,
    input  logic             lock_i,
    input  logic [TMO_W-1:0] limit_i,
    output sw_stat_t         stat_o,
    output logic             req_o
);

    localparam logic [SEL_W-1:0] RST_V = SEL_W'(RST_SEL);

    sw_stat_t         st_q;
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_nx;
    logic             expired;
    logic             waiting;

    assign waiting = st_q.en && !st_q.fail;
    assign cnt_nx  = {1'b0, cnt_q} + 1'b1;
    assign expired = cnt_nx >= {1'b0, limit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.en   <= 1'b0;
            st_q.fail <= 1'b0;
            st_q.lock <= 1'b0;
            st_q.cur  <= RST_V;
            cnt_q     <= '0;
        end else begin
            st_q.lock <= lock_i;
            if (start_i) begin
                st_q.en   <= 1'b1;
                st_q.fail <= 1'b0;
                cnt_q     <= '0;
            end else if (waiting) begin
                if (ready_i) begin
                    st_q.cur <= nsel_i;
                    st_q.en  <= 1'b0;
                end else if (expired) begin
                    st_q.fail <= 1'b1;
                end else begin
                    cnt_q <= cnt_nx[TMO_W-1:0];
                end
            end
        end
    end

    assign stat_o = st_q;
    assign req_o  = waiting;

    // R6
    commit_value_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.en) |-> (st_q.cur == $past(nsel_i)));

    // R7
    fail_keeps_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.fail) |-> st_q.en);

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.en) |-> $past(start_i));

    // R8
    lock_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.lock == $past(lock_i)));

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter int unsigned LO_ADDR = 0,
    parameter int unsigned HI_ADDR = 1,
    parameter int          TMO_W   = 8,
    parameter int          RST_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              osc_ready,
    input  logic              osc_lock,
    output logic [2:0]        cur_sel,
    output logic [2:0]        tgt_sel,
    output logic              sw_req
);

    localparam logic [SEL_W-1:0]  RST_V  = SEL_W'(RST_SEL);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HI_ADDR);

    logic [LANES-1:0] grant;
    logic [SEL_W-1:0] new_sel_q;
    logic             start;
    sw_stat_t         stat;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        key_lane #(
            .ADDR_W   (ADDR_W),
            .LANE_ADDR((gi == LN_HI) ? HI_ADDR : LO_ADDR),
            .KEY_A    (key_first(gi)),
            .KEY_B    (key_second(gi))
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .grant_o(grant[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)               new_sel_q <= RST_V;
        else if (grant[LN_HI]) new_sel_q <= wr_data[HI_NEW_LSB +: SEL_W];
    end

    assign start = grant[LN_LO] && wr_data[LO_EN_BIT];

    switch_seq #(
        .TMO_W  (TMO_W),
        .RST_SEL(RST_SEL)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .nsel_i (new_sel_q),
        .ready_i(osc_ready),
        .lock_i (osc_lock),
        .limit_i(tmo_limit),
        .stat_o (stat),
        .req_o  (sw_req)
    );

    always_comb begin
        if (rd_addr == A_HI)      rd_data = pack_hi(new_sel_q, stat.cur);
        else if (rd_addr == A_LO) rd_data = pack_lo(stat);
        else                      rd_data = '0;
    end

    assign cur_sel = stat.cur;
    assign tgt_sel = new_sel_q;

    // R5
    new_sel_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(new_sel_q) |-> $past(grant[LN_HI]));

    // R7
    no_req_when_failed_chk: assert property (@(posedge clk) disable iff (rst)
        stat.fail |-> !sw_req);

endmodule

// File: tb/clksel_ctrl_tb.sv
`timescale 1ns/100ps
module clksel_ctrl_tb;

    localparam logic [3:0] LO = 4'd0;
    localparam logic [3:0] HI = 4'd1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [3:0] wa = '0;
    logic [7:0] wd = '0;
    logic [3:0] ra = '0;
    logic [7:0] rd;
    logic [7:0] lim = 8'd4;
    logic       rdy = 1'b0;
    logic       lk = 1'b0;
    logic [2:0] cur, tgt;
    logic       req;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // bench reference state
    int       m_st_lo, m_st_hi;
    logic [2:0] m_nsel, m_cur;
    logic     m_en, m_fail, m_lock;
    int       m_cnt;

    always #2.5 clk = ~clk;

    clksel_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_addr(ra), .rd_data(rd), .tmo_limit(lim), .osc_ready(rdy),
        .osc_lock(lk), .cur_sel(cur), .tgt_sel(tgt), .sw_req(req)
    );

    function automatic int lane_next(int st, bit hit, logic [7:0] d,
                                     logic [7:0] ka, logic [7:0] kb);
        if (st == 0) return (hit && d == ka) ? 1 : 0;
        if (st == 1) return (hit && d == kb) ? 2 : 0;
        return 0;
    endfunction

    function automatic logic [7:0] exp_hi();
        return {1'b0, m_cur, 1'b0, m_nsel};
    endfunction

    function automatic logic [7:0] exp_lo();
        return {2'b00, m_lock, 1'b0, m_fail, 2'b00, m_en};
    endfunction

    task automatic mdl_reset();
        m_st_lo = 0; m_st_hi = 0; m_nsel = 3'd0; m_cur = 3'd0;
        m_en = 0; m_fail = 0; m_lock = 0; m_cnt = 0;
    endtask

    task automatic mdl_update(bit w, logic [3:0] a, logic [7:0] d, bit r);
        bit hl, hh, gl, gh;
        int lm;
        hl = w && a == LO;
        hh = w && a == HI;
        gl = (m_st_lo == 2) && hl;
        gh = (m_st_hi == 2) && hh;
        lm = (lim == 0) ? 1 : int'(lim);
        if (gl && d[0]) begin
            m_en = 1; m_fail = 0; m_cnt = 0;
        end else if (m_en && !m_fail) begin
            if (r) begin
                m_cur = m_nsel; m_en = 0;
            end else if (m_cnt + 1 >= lm) begin
                m_fail = 1;
            end else begin
                m_cnt++;
            end
        end
        if (gh) m_nsel = d[2:0];
        m_lock  = lk;
        m_st_lo = lane_next(m_st_lo, hl, d, 8'h46, 8'h57);
        m_st_hi = lane_next(m_st_hi, hh, d, 8'h78, 8'h9A);
    endtask

    task automatic step(bit w, logic [3:0] a, logic [7:0] d, bit r);
        we = w; wa = a; wd = d; rdy = r;
        @(posedge clk); #1;
        mdl_update(w, a, d, r);
        we = 0; rdy = 0; wd = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, LO, 8'h00, 0);
    endtask

    task automatic chk(string req_tag, string what, int act, int expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, expv);
        end
    endtask

    task automatic read_at(logic [3:0] a, output logic [7:0] v);
        ra = a; #0.2; v = rd;
    endtask

    task automatic chk_mdl(string req_tag);
        logic [7:0] v;
        chk(req_tag, "cur_sel", cur, m_cur);
        chk(req_tag, "tgt_sel", tgt, m_nsel);
        chk(req_tag, "sw_req", req, m_en && !m_fail);
        read_at(HI, v); chk(req_tag, "read high", v, exp_hi());
        read_at(LO, v); chk(req_tag, "read low", v, exp_lo());
    endtask

    task automatic hi_write(logic [7:0] d);
        step(1, HI, 8'h78, 0); step(1, HI, 8'h9A, 0); step(1, HI, d, 0);
    endtask

    task automatic lo_write(logic [7:0] d);
        step(1, LO, 8'h46, 0); step(1, LO, 8'h57, 0); step(1, LO, d, 0);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int seed;
        seed = $urandom(32'h0C1C5E1);
        mdl_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state, while still in reset
        chk("R1", "sw_req in reset", req, 0);
        chk("R1", "cur_sel in reset", cur, 0);
        rst = 0;
        chk_mdl("R1");

        // R2 normal high unlock and write; R9 layout of high read
        hi_write(8'h05);
        chk("R2", "tgt_sel", tgt, 5);
        read_at(HI, v); chk("R9", "high read layout", v, 8'h05);

        // R4 wrong second key
        step(1, HI, 8'h78, 0); step(1, HI, 8'h9B, 0); step(1, HI, 8'h01, 0);
        chk("R4", "tgt after wrong key", tgt, 5);
        // R4 idle cycle after second key
        step(1, HI, 8'h78, 0); step(1, HI, 8'h9A, 0); step(0, HI, 8'h00, 0);
        step(1, HI, 8'h01, 0);
        chk("R4", "tgt after gap", tgt, 5);
        // R4 intervening write to other address
        step(1, HI, 8'h78, 0); step(1, LO, 8'h00, 0); step(1, HI, 8'h9A, 0);
        step(1, HI, 8'h01, 0);
        chk("R4", "tgt after interleave", tgt, 5);
        // R5 write with no unlock
        step(1, HI, 8'h07, 0); step(1, LO, 8'h01, 0);
        chk("R5", "tgt unlocked-less", tgt, 5);
        chk("R5", "sw_req unlocked-less", req, 0);
        // R5 unlocked low write of 0
        lo_write(8'h00);
        read_at(LO, v); chk("R5", "low read after zero write", v, 8'h00);

        // R3 start, R6 success on second waiting edge
        lim = 8'd4;
        lo_write(8'h01);
        chk("R3", "sw_req after start", req, 1);
        read_at(LO, v); chk("R9", "low read en", v, 8'h01);
        step(0, LO, 8'h00, 0);
        step(0, LO, 8'h00, 1);
        chk("R6", "cur after ready", cur, 5);
        chk("R6", "sw_req after ready", req, 0);
        read_at(HI, v); chk("R9", "high read both", v, 8'h55);

        // R7 timeout with limit 4
        hi_write(8'h02);
        lo_write(8'h01);
        idle(3);
        read_at(LO, v); chk("R7", "no fail before limit", v, 8'h01);
        idle(1);
        read_at(LO, v); chk("R7", "fail at limit", v, 8'h09);
        chk("R7", "sw_req after fail", req, 0);
        step(0, LO, 8'h00, 1);
        chk("R7", "ready ignored after fail", cur, 5);
        // R8 lock mirror
        lk = 1; step(0, LO, 8'h00, 0);
        read_at(LO, v); chk("R8", "lock bit set", v, 8'h29);
        lk = 0; step(0, LO, 8'h00, 0);
        read_at(LO, v); chk("R8", "lock bit clear", v, 8'h09);

        // R3 retry clears fail
        lo_write(8'h01);
        read_at(LO, v); chk("R3", "retry clears fail", v, 8'h01);
        step(0, LO, 8'h00, 1);
        chk("R6", "cur after retry", cur, 2);

        // R10 same-edge write and ready
        hi_write(8'h03);
        lo_write(8'h01);
        step(1, HI, 8'h78, 0); step(1, HI, 8'h9A, 0); step(1, HI, 8'h06, 1);
        chk("R10", "cur takes old request", cur, 3);
        chk("R10", "tgt takes new write", tgt, 6);
        chk("R10", "sw_req cleared", req, 0);

        // R11 one write per unlock
        step(1, HI, 8'h78, 0); step(1, HI, 8'h9A, 0);
        step(1, HI, 8'h01, 0); step(1, HI, 8'h04, 0);
        chk("R11", "second write ignored", tgt, 1);

        // R9 unused address reads zero
        read_at(4'hF, v); chk("R9", "other address", v, 8'h00);

        // R7 limit of zero fails after one waiting edge
        lim = 8'd0;
        lo_write(8'h01);
        step(0, LO, 8'h00, 0);
        read_at(LO, v); chk("R7", "limit zero", v, 8'h09);
        chk_mdl("R7");

        // random phase against reference model
        lim = 8'd5;
        for (int it = 0; it < 1500; it++) begin
            int    sel;
            bit    lane_hi;
            logic [3:0] a;
            sel = $urandom % 10;
            lk  = ($urandom % 4) != 0;
            if (sel < 6) begin
                lane_hi = sel < 3;
                a = lane_hi ? HI : LO;
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] d;
                    bit r;
                    d = (k == 0) ? (lane_hi ? 8'h78 : 8'h46) :
                        (k == 1) ? (lane_hi ? 8'h9A : 8'h57) : 8'($urandom);
                    r = ($urandom % 6) == 0;
                    if (($urandom % 5) == 0)
                        step($urandom % 2, 4'($urandom % 3), 8'($urandom), r);
                    else
                        step(1, a, d, r);
                    // R4 each cycle compared with model
                    chk_mdl("R4");
                end
            end else begin
                step($urandom % 2, 4'($urandom % 3), 8'($urandom), ($urandom % 6) == 0);
                chk_mdl("R6");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule